// File: doc/BRIEF.md
# Four-Channel DAC Load and Clear Controller

This block is the digital control core of a four-channel, serially programmed digital-to-analog converter. The bits of a serial frame reach it one per accepted beat on a valid/ready stream. The frame is opened and closed by an active-low frame-select strobe. When the frame is closed, the block decodes it as one of four register writes: a channel data code, a channel output range, the power-control word, or the control register. Every channel has two code registers. The input register takes each accepted data write. The DAC register holds the code that drives the converter, which is this block's output.

A load strobe picks when the DAC register takes the new code. If the strobe is low while a frame is shifted in, the addressed channel commits the code as soon as the frame closes. If the strobe is high, the code only waits in the input register, and all channels commit together on the next falling edge of the load strobe. An active-low clear pin forces every DAC register to zero-scale or midscale, and a control-register command does the same. The block drops writes to channels that are powered down. It converts twos-complement codes for channels set to a bipolar range.

Top module: `dac_quad_ctrl`

## Requirements
- R1: After reset, all DAC registers read 0, the reference enable is 0, every channel is powered down, and every channel range is 0 (the 5 V unipolar range). A data write sent before any power-up changes no output.
- R2: `bit_ready` is high only while `frame_n` is low and fewer than 24 bits of the current frame have been taken. A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. Bits arrive MSB first.
- R3: A frame is processed on the clock edge where `frame_n` is first sampled high. A frame that closes with fewer than 24 bits writes no register.
- R4: A data write to a channel whose power bit is 0 at frame close changes neither its input register nor its DAC register.
- R5: Frame layout, from bit 23 down: bit 23 is read (1) or write (0). Bits 22:20 select the register: 0 data, 1 range, 2 power, 3 control. Bit 19 is reserved and must be 0. Bits 18:16 give the channel (0 to 3, or 4 for all channels). Bits 15:0 are the payload, and a data code is payload[15:2]. If `ldac_n` is low at frame close, the addressed DAC register takes the code on that same edge.
- R6: If `ldac_n` is high at frame close, only the input register is written. Every DAC register copies its input register on the edge where `ldac_n` is first sampled low while `frame_n` is high. A DAC register changes at no other time, except through a clear.
- R7: While `clr_n` is sampled low, every DAC register takes the clear code and accepts nothing else. The clear code is 0x0000 if clear-select is 0 and 0x2000 if it is 1. Clear-select is control write address 1, payload[0]. After `clr_n` is released, the clear code stays in place until a new code is loaded.
- R8: A control write to address 4 forces every DAC register to the clear code on the frame-close edge.
- R9: If a channel's range is 3, 4 or 5 (bipolar) and `twos_sel` is 1, the stored code has bit 13 inverted. Range codes 0 to 2 (unipolar) store the code unchanged.
- R10: Channel address 4 applies a data or range write to every channel. For a data write, each channel is still gated by its own power bit.
- R11: The power word is payload[3:0] for the channel power-up bits and payload[4] for the reference, which drives `ref_en`. A read frame, a frame with the reserved bit set, and a frame with an unused register select all change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame select |
| bit_valid | input | 1 | Serial bit offered |
| bit_ready | output | 1 | Bit accepted on this edge when valid |
| bit_data | input | 1 | Serial bit, MSB first |
| ldac_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Clear, active low |
| twos_sel | input | 1 | Bipolar coding: 1 twos complement, 0 offset binary |
| dac_codes | output | 56 | DAC register codes, channel n in bits n*14 +: 14 |
| ref_en | output | 1 | Reference power-up bit |

## Verification
The bench builds the block with its default parameters: four channels, 14-bit codes and a 24-bit frame. With these values all four addresses, the all-channels address and the midscale bit at position 13 can be reached directly. A behavioural model in the bench follows every frame, load-strobe edge and clear cycle, and its outputs are compared with the block's outputs every clock. The stimulus covers short frames, read and reserved-bit frames, writes to channels that are powered down, both load modes, the pin clear and the command clear, and twos-complement conversion on a bipolar channel next to a unipolar one.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int FRAME_W = 24;
  localparam int PAY_W   = 16;

  localparam logic [2:0] SEL_DATA  = 3'd0;
  localparam logic [2:0] SEL_RANGE = 3'd1;
  localparam logic [2:0] SEL_POWER = 3'd2;
  localparam logic [2:0] SEL_CTRL  = 3'd3;

  localparam logic [2:0] ADDR_ALL   = 3'd4;
  localparam logic [2:0] CTRL_SET   = 3'd1;
  localparam logic [2:0] CTRL_CLEAR = 3'd4;

  localparam logic [2:0] RANGE_BIPOLAR_MIN = 3'd3;

  typedef struct packed {
    logic             rd;
    logic [2:0]       sel;
    logic             rsv;
    logic [2:0]       addr;
    logic [PAY_W-1:0] payload;
  } frame_t;
endpackage

// File: rtl/dacq_frame_rx.sv
module dacq_frame_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               bit_valid,
  input  logic               bit_data,
  output logic               bit_ready,
  output logic               frame_end,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               frame_q;

  assign bit_ready  = !frame_n && (cnt < CNT_W'(FRAME_W));
  assign frame_end  = frame_n && !frame_q;
  assign frame_ok   = frame_end && (cnt == CNT_W'(FRAME_W));
  assign frame_word = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_n;
      if (frame_n) begin
        cnt <= '0;
      end else if (bit_valid && bit_ready) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[FRAME_W-2:0], bit_data};
      end
    end
  end
endmodule

// File: rtl/dacq_cfg_regs.sv
module dacq_cfg_regs
  import dacq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_ok,
  input  frame_t         word,
  output logic [NCH-1:0] data_we,
  output logic [NCH-1:0] bipolar,
  output logic [NCH-1:0] pwr_bits,
  output logic           ref_en,
  output logic           clr_sel,
  output logic           clr_cmd
);
  logic           wr_ok;
  logic [NCH-1:0] hit;
  logic [2:0]     range_q [NCH];

  assign wr_ok   = frame_ok && !word.rd && !word.rsv;
  assign clr_cmd = wr_ok && word.sel == SEL_CTRL && word.addr == CTRL_CLEAR;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g]     = (word.addr == 3'(g)) || (word.addr == ADDR_ALL);
    assign data_we[g] = wr_ok && word.sel == SEL_DATA && hit[g] && pwr_bits[g];
    assign bipolar[g] = range_q[g] >= RANGE_BIPOLAR_MIN;

    always_ff @(posedge clk) begin
      if (!rst_n)
        range_q[g] <= '0;
      else if (wr_ok && word.sel == SEL_RANGE && hit[g])
        range_q[g] <= word.payload[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_bits <= '0;
      ref_en   <= 1'b0;
      clr_sel  <= 1'b0;
    end else if (wr_ok) begin
      if (word.sel == SEL_POWER) begin
        pwr_bits <= word.payload[NCH-1:0];
        ref_en   <= word.payload[NCH];
      end
      if (word.sel == SEL_CTRL && word.addr == CTRL_SET)
        clr_sel <= word.payload[0];
    end
  end
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              bipolar,
  input  logic              twos_sel,
  input  logic              direct,
  input  logic              load_all,
  input  logic              clr_force,
  input  logic [CODE_W-1:0] clr_code,
  output logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] dac_code
);
  localparam logic [CODE_W-1:0] MSB_FLIP = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] conv;
  assign conv = (bipolar && twos_sel) ? (wr_code ^ MSB_FLIP) : wr_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_code  <= '0;
      dac_code <= '0;
    end else begin
      if (wr_en) in_code <= conv;
      if (clr_force)             dac_code <= clr_code;
      else if (wr_en && direct)  dac_code <= conv;
      else if (load_all)         dac_code <= in_code;
    end
  end
endmodule

// File: rtl/dac_quad_ctrl.sv
module dac_quad_ctrl
  import dacq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_n,
  input  logic                  bit_valid,
  output logic                  bit_ready,
  input  logic                  bit_data,
  input  logic                  ldac_n,
  input  logic                  clr_n,
  input  logic                  twos_sel,
  output logic [NCH*CODE_W-1:0] dac_codes,
  output logic                  ref_en
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic                  frame_end, frame_ok, ldac_q, ldac_fall;
  logic                  clr_sel, clr_cmd, clr_force;
  logic [FRAME_W-1:0]    word_bits;
  frame_t                frame_word;
  logic [NCH-1:0]        data_we, bipolar, pwr_bits;
  logic [NCH*CODE_W-1:0] in_codes;
  logic [CODE_W-1:0]     clr_code;

  dacq_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .frame_end(frame_end),
    .frame_ok(frame_ok), .frame_word(word_bits)
  );
  assign frame_word = frame_t'(word_bits);

  dacq_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .word(frame_word),
    .data_we(data_we), .bipolar(bipolar), .pwr_bits(pwr_bits),
    .ref_en(ref_en), .clr_sel(clr_sel), .clr_cmd(clr_cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ldac_q <= 1'b1;
    else        ldac_q <= ldac_n;
  end

  assign ldac_fall = !ldac_n && ldac_q && frame_n;
  assign clr_force = !clr_n || clr_cmd;
  assign clr_code  = clr_sel ? MID_CODE : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dacq_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(data_we[g]),
      .wr_code(frame_word.payload[PAY_W-1 -: CODE_W]),
      .bipolar(bipolar[g]), .twos_sel(twos_sel), .direct(!ldac_n),
      .load_all(ldac_fall), .clr_force(clr_force), .clr_code(clr_code),
      .in_code(in_codes[g*CODE_W +: CODE_W]),
      .dac_code(dac_codes[g*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_quad_ctrl_chk.sv
module dac_quad_ctrl_chk
  import dacq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_n,
  input logic                  bit_ready,
  input logic                  clr_n,
  input logic                  frame_end,
  input logic                  frame_ok,
  input logic                  ldac_fall,
  input logic                  clr_sel,
  input logic [FRAME_W-1:0]    word_bits,
  input logic [NCH-1:0]        pwr_bits,
  input logic [NCH*CODE_W-1:0] in_codes,
  input logic [NCH*CODE_W-1:0] dac_codes
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  frame_t w;
  assign w = frame_t'(word_bits);

  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> !frame_n);

  p_short_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> ($stable(in_codes) && $stable(pwr_bits)));

  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !frame_ok && !ldac_fall) |=> $stable(dac_codes));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_pd_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && !w.rd && w.sel == SEL_DATA &&
       (w.addr == 3'(g) || w.addr == ADDR_ALL) && !pwr_bits[g])
      |=> $stable(in_codes[g*CODE_W +: CODE_W]));

    p_clear_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (dac_codes[g*CODE_W +: CODE_W] ==
                  ($past(clr_sel) ? MID_CODE : '0)));
  end
endmodule

bind dac_quad_ctrl dac_quad_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bit_ready(bit_ready),
  .clr_n(clr_n), .frame_end(frame_end), .frame_ok(frame_ok),
  .ldac_fall(ldac_fall), .clr_sel(clr_sel), .word_bits(word_bits),
  .pwr_bits(pwr_bits), .in_codes(in_codes), .dac_codes(dac_codes)
);

// File: tb/tb_dac_quad_ctrl.sv
module tb_dac_quad_ctrl;
  localparam int NCH = 4;
  localparam int CW  = 14;

  logic clk = 0, rst_n = 0, frame_n = 1, bit_valid = 0, bit_data = 0;
  logic ldac_n = 1, clr_n = 1, twos_sel = 0;
  logic bit_ready, ref_en;
  logic [NCH*CW-1:0] dac_codes;

  int checks = 0, errors = 0;
  string cur = "R1";
  bit run_model = 0;

  always #2.5 clk = ~clk;

  dac_quad_ctrl #(.NCH(NCH), .CODE_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .ldac_n(ldac_n),
    .clr_n(clr_n), .twos_sel(twos_sel), .dac_codes(dac_codes), .ref_en(ref_en)
  );

  // Behavioural reference model
  int m_in[NCH], m_dac[NCH], m_rng[NCH];
  int m_pwr, m_ref, m_csel, m_cnt, m_pf, m_pl;
  logic [23:0] m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; m_rng[i] = 0; end
      m_pwr = 0; m_ref = 0; m_csel = 0; m_cnt = 0; m_pf = 1; m_pl = 1; m_w = 0;
    end else begin
      int clrv;
      int old_in[NCH];
      clrv = m_csel ? 'h2000 : 0;
      foreach (old_in[i]) old_in[i] = m_in[i];
      if (frame_n && !m_pf && m_cnt == 24 && !m_w[23] && !m_w[19]) begin
        for (int c = 0; c < NCH; c++) begin
          if (m_w[18:16] == c || m_w[18:16] == 4) begin
            if (m_w[22:20] == 0 && m_pwr[c]) begin
              int v;
              v = m_w[15:2];
              if (m_rng[c] >= 3 && twos_sel) v = v ^ 'h2000;
              m_in[c] = v;
              if (!ldac_n) m_dac[c] = v;
            end
            if (m_w[22:20] == 1) m_rng[c] = m_w[2:0];
          end
        end
        if (m_w[22:20] == 2) begin m_pwr = m_w[3:0]; m_ref = m_w[4]; end
        if (m_w[22:20] == 3 && m_w[18:16] == 1) m_csel = m_w[0];
        if (m_w[22:20] == 3 && m_w[18:16] == 4)
          foreach (m_dac[i]) m_dac[i] = clrv;
      end
      if (!ldac_n && m_pl && frame_n && !(frame_n && !m_pf && m_cnt == 24))
        foreach (m_dac[i]) m_dac[i] = old_in[i];
      if (!clr_n) foreach (m_dac[i]) m_dac[i] = clrv;
      if (frame_n) begin m_cnt = 0; end
      else if (bit_valid && m_cnt < 24) begin m_w = {m_w[22:0], bit_data}; m_cnt++; end
      m_pf = frame_n; m_pl = ldac_n;
    end
  end

  task automatic check(string req, int got, int exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (run_model && rst_n) begin
      for (int c = 0; c < NCH; c++)
        check(cur, dac_codes[c*CW +: CW], m_dac[c], $sformatf("model dac ch%0d", c));
      check(cur, ref_en, m_ref, "model ref_en");
      check(cur, bit_ready, (!frame_n && m_cnt < 24), "model bit_ready");
    end
  end

  function automatic int dac(int c);
    return dac_codes[c*CW +: CW];
  endfunction

  function automatic logic [23:0] mk(bit rd, int sel, bit rsv, int addr, int pay);
    return {rd, 3'(sel), rsv, 3'(addr), 16'(pay)};
  endfunction

  task automatic send(logic [23:0] w, int nbits, logic ld);
    @(negedge clk);
    ldac_n = ld; frame_n = 0;
    for (int i = 0; i < nbits; i++) begin
      bit_valid = 1; bit_data = w[23-i];
      @(negedge clk);
    end
    bit_valid = 0;
    @(negedge clk); #1;
    if (nbits == 24) check("R2", bit_ready, 0, "ready after full frame");
    @(negedge clk);
    frame_n = 1;
    @(negedge clk); @(negedge clk);
    ldac_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_ldac();
    @(negedge clk); ldac_n = 0;
    @(negedge clk); ldac_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; run_model = 1;
    @(negedge clk); #1;
    cur = "R1";
    check("R1", dac_codes[31:0], 0, "reset dac low");
    check("R1", dac_codes[NCH*CW-1:32], 0, "reset dac high");
    check("R1", ref_en, 0, "reset ref_en");
    check("R2", bit_ready, 0, "idle ready");

    cur = "R4";
    send(mk(0, 0, 0, 0, 'hFFFC), 24, 0);
    check("R4", dac(0), 0, "powered-down write");

    cur = "R11";
    send(mk(0, 2, 0, 0, 'h1F), 24, 1);
    check("R11", ref_en, 1, "power word ref bit");

    cur = "R5";
    send(mk(0, 0, 0, 1, 'h1234 << 2), 24, 0);
    check("R5", dac(1), 'h1234, "direct update");

    cur = "R6";
    send(mk(0, 0, 0, 2, 'h0AAA << 2), 24, 1);
    send(mk(0, 0, 0, 3, 'h3001 << 2), 24, 1);
    check("R6", dac(2), 0, "held before ldac");
    check("R6", dac(3), 0, "held before ldac");
    pulse_ldac();
    check("R6", dac(2), 'h0AAA, "ldac fall ch2");
    check("R6", dac(3), 'h3001, "ldac fall ch3");
    check("R6", dac(1), 'h1234, "ldac fall ch1");

    cur = "R3";
    send(mk(0, 0, 0, 0, 'h0100), 20, 0);
    check("R3", dac(0), 0, "short frame dropped");

    cur = "R11";
    send(mk(1, 0, 0, 1, 'h0040), 24, 0);
    send(mk(0, 0, 1, 1, 'h0040), 24, 0);
    send(mk(0, 6, 0, 1, 'h0040), 24, 0);
    check("R11", dac(1), 'h1234, "read/reserved/unused ignored");

    cur = "R10";
    send(mk(0, 2, 0, 0, 'h0B), 24, 1);
    send(mk(0, 0, 0, 4, 'h0100 << 2), 24, 0);
    check("R10", dac(0), 'h0100, "all ch0");
    check("R10", dac(3), 'h0100, "all ch3");
    check("R10", dac(2), 'h0AAA, "all skips powered-down ch2");

    cur = "R9";
    twos_sel = 1;
    send(mk(0, 1, 0, 0, 3), 24, 1);
    send(mk(0, 0, 0, 0, 5 << 2), 24, 0);
    send(mk(0, 0, 0, 1, 5 << 2), 24, 0);
    check("R9", dac(0), 'h2005, "bipolar twos");
    check("R9", dac(1), 'h0005, "unipolar straight");
    twos_sel = 0;
    send(mk(0, 0, 0, 0, 5 << 2), 24, 0);
    check("R9", dac(0), 'h0005, "bipolar offset binary");

    cur = "R7";
    send(mk(0, 3, 0, 1, 1), 24, 1);
    @(negedge clk); clr_n = 0;
    @(negedge clk); #1;
    check("R7", dac(0), 'h2000, "midscale clear");
    check("R7", dac(3), 'h2000, "midscale clear ch3");
    send(mk(0, 0, 0, 1, 'h0777 << 2), 24, 0);
    check("R7", dac(1), 'h2000, "blocked while clear");
    @(negedge clk); clr_n = 1;
    repeat (3) @(negedge clk);
    check("R7", dac(1), 'h2000, "held after release");
    pulse_ldac();
    check("R7", dac(1), 'h0777, "new code after release");

    cur = "R8";
    send(mk(0, 3, 0, 1, 0), 24, 1);
    send(mk(0, 3, 0, 4, 0), 24, 1);
    check("R8", dac(1), 0, "command clear ch1");
    check("R8", dac(3), 0, "command clear ch3");

    cur = "R2";
    repeat (4) @(negedge clk);
    run_model = 0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule